// File: doc/BRIEF.md
# Hashed Page Table Group Search

This block looks up one translation in a single group of a hashed page table. On an accepted start it takes a virtual page number, a base page size, an actual page size, a segment size and a secondary-search flag. From these it builds the first doubleword that a matching table entry would carry, and it holds that expected word for the rest of the search. It then reads the eight entries of the group one per cycle through a synchronous read port, one cycle of read latency, and compares each entry's first doubleword with the expected word. The address of the group, a retry in the secondary group, and writing entries all belong to the caller.

The abbreviated page number is the page number shifted right by 11, with the bits selected by a per-base-page-size mask cleared. That mask comes from a small register table that is loaded through a configuration write port. The result is placed at bit 7 and up. The 2-bit segment size sits at bit 62, and a large flag at bit 2 marks any actual page size other than 4 KB. The compare ignores the seven flag bits at the bottom of the word. Separately, a hit requires the entry's valid bit and a secondary bit equal to the search flag. The first hitting slot in ascending order ends the search. If no slot hits, the block reports a miss after all eight slots.

Top module: `hpt_group_search`

## Requirements
- R1: After reset, busy_o, done_o, hit_o and rd_en_o are 0 and exp_v_o is 0.
- R2: One cycle after an accepted start, exp_v_o[63:7] equals ((vpn_i >> 11) & ~mask[base_psize_i]) << 7 truncated to 64 bits, with ssize_i ORed in at bits 63:62. Bits 6:3, 1 and 0 are 0.
- R3: exp_v_o bit 2 is 1 exactly when act_psize_i is not 0, where code 0 means 4 KB pages.
- R4: An entry word matches when it equals exp_v_o in bits 63:7. Entry bits 6:2 (large, lock, bolted and two spare bits) do not affect the result.
- R5: A matching entry whose bit 0 (valid) is 0 is not a hit.
- R6: A matching entry is a hit only if its bit 1 (secondary) equals secondary_i.
- R7: When several slots hit, the lowest slot index is reported. Slots are read in ascending order, one per cycle.
- R8: With the start sampled at clock edge E0, slot k is read in the cycle after edge Ek. For a hit at slot k, done_o is high for one cycle after edge E(k+2), with hit_o=1, slot_o=k and r_o set to that entry's second doubleword.
- R9: When no slot hits, done_o rises after edge E9 with hit_o=0, slot_o=7 and r_o=0.
- R10: A start_i that arrives while busy_o is 1 is ignored: exp_v_o does not change and no extra done_o occurs.
- R11: cfg_we_i writes cfg_mask_i into the mask entry selected by cfg_idx_i. All entries reset to 0. A write made during a search does not alter that search.
- R12: hit_o, slot_o and r_o hold their values from one done until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a search; accepted only when idle |
| vpn_i | input | 64 | Virtual page number |
| base_psize_i | input | 2 | Base page size code, indexes the mask table |
| act_psize_i | input | 2 | Actual page size code, 0 = 4 KB |
| ssize_i | input | 2 | Segment size code |
| secondary_i | input | 1 | Required value of the entry secondary bit |
| cfg_we_i | input | 1 | Mask table write enable |
| cfg_idx_i | input | 2 | Mask table entry to write |
| cfg_mask_i | input | 64 | Mask value to write |
| rd_en_o | output | 1 | Entry read request |
| rd_slot_o | output | 3 | Slot index of the read |
| rd_v_i | input | 64 | First doubleword, one cycle after the request |
| rd_r_i | input | 64 | Second doubleword, one cycle after the request |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle result strobe |
| hit_o | output | 1 | Result: a slot hit |
| slot_o | output | 3 | Result slot index |
| r_o | output | 64 | Second doubleword of the hit entry |
| exp_v_o | output | 64 | Expected first doubleword of the current search |

## Verification
The bench places entries that agree with the expected word in bits 63:7 but differ in the low flags. A compare that covered too many bits would miss these, and one that covered too few would pass entries that differ only at bit 7 or bit 63. Invalid entries and entries with the wrong secondary bit sit ahead of real hits, so a design that skipped either gate would report an earlier slot. Two hitting slots check lowest-index priority, and per-result latency checks catch a read or compare pipeline that is off by a cycle. A start and a mask write made during a search must leave the latched key and the single result untouched. Otherwise the design would restart, or show a second done or a wrong slot.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int VALID_BIT = 0;
  localparam int SEC_BIT   = 1;
  localparam int LARGE_BIT = 2;
  localparam int AVPN_POS  = 7;
  localparam int SSZ_POS   = 62;
  localparam int SSZ_W     = 2;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_SCAN = 1'b1
  } scan_state_e;
endpackage

// File: rtl/hpt_mask_table.sv
module hpt_mask_table #(
  parameter int DW        = 64,
  parameter int NUM_PSIZE = 4,
  localparam int PSW      = $clog2(NUM_PSIZE)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [PSW-1:0] widx_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [PSW-1:0] ridx_i,
  output logic [DW-1:0]  rdata_o
);
  logic [DW-1:0] mask_q [NUM_PSIZE];

  for (genvar g = 0; g < NUM_PSIZE; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mask_q[g] <= '0;
      else if (we_i && widx_i == PSW'(g))        mask_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mask_q[ridx_i];

  p_write_lands_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mask_q[$past(widx_i)] == $past(wdata_i));
endmodule

// File: rtl/hpt_key_build.sv
module hpt_key_build
  import hpt_pkg::*;
#(
  parameter int DW         = 64,
  parameter int PSW        = 2,
  parameter int AVPN_SHIFT = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             busy_i,
  input  logic [DW-1:0]    vpn_i,
  input  logic [DW-1:0]    mask_i,
  input  logic [PSW-1:0]   act_psize_i,
  input  logic [SSZ_W-1:0] ssize_i,
  input  logic             sec_i,
  output logic [DW-1:0]    key_o,
  output logic             sec_o
);
  logic [DW-1:0] avpn_w;
  logic [DW-1:0] key_d;
  logic [DW-1:0] key_q;
  logic          sec_q;

  always_comb begin
    avpn_w = (vpn_i >> AVPN_SHIFT) & ~mask_i;
    key_d  = (avpn_w << AVPN_POS) | ({{(DW-SSZ_W){1'b0}}, ssize_i} << SSZ_POS);
    key_d[LARGE_BIT] = (act_psize_i != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q <= '0;
      sec_q <= 1'b0;
    end else if (load_i) begin
      key_q <= key_d;
      sec_q <= sec_i;
    end
  end

  assign key_o = key_q;
  assign sec_o = sec_q;

  p_key_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(key_q) && $stable(sec_q));
  p_flags_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_q[AVPN_POS-1:LARGE_BIT+1] == '0 && key_q[SEC_BIT:VALID_BIT] == '0);
endmodule

// File: rtl/hpt_group_scan.sv
module hpt_group_scan
  import hpt_pkg::*;
#(
  parameter int DW    = 64,
  parameter int SLOTS = 8,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int CNT_W  = SLOT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DW-1:0]     key_i,
  input  logic              sec_i,
  output logic              load_o,
  output logic              rd_en_o,
  output logic [SLOT_W-1:0] rd_slot_o,
  input  logic [DW-1:0]     rd_v_i,
  input  logic [DW-1:0]     rd_r_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              hit_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [DW-1:0]     r_o
);
  localparam logic [DW-1:0] CMP_MASK = {{(DW-AVPN_POS){1'b1}}, {AVPN_POS{1'b0}}};

  scan_state_e       state_q;
  logic [CNT_W-1:0]  issue_q;
  logic              cmp_valid_q;
  logic [SLOT_W-1:0] cmp_slot_q;
  logic              done_q, hit_q;
  logic [SLOT_W-1:0] slot_q;
  logic [DW-1:0]     r_q;
  logic              match_w, last_w, finish_w;

  assign load_o    = start_i && (state_q == S_IDLE);
  assign rd_en_o   = (state_q == S_SCAN) && (issue_q < CNT_W'(SLOTS));
  assign rd_slot_o = issue_q[SLOT_W-1:0];

  // Tag bits 63:7, then the valid and secondary gates
  assign match_w  = cmp_valid_q && (((rd_v_i ^ key_i) & CMP_MASK) == '0)
                    && rd_v_i[VALID_BIT] && (rd_v_i[SEC_BIT] == sec_i);
  assign last_w   = cmp_valid_q && (cmp_slot_q == SLOT_W'(SLOTS-1));
  assign finish_w = match_w || last_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      issue_q     <= '0;
      cmp_valid_q <= 1'b0;
      cmp_slot_q  <= '0;
      done_q      <= 1'b0;
      hit_q       <= 1'b0;
      slot_q      <= '0;
      r_q         <= '0;
    end else if (load_o) begin
      state_q     <= S_SCAN;
      issue_q     <= '0;
      cmp_valid_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q == S_SCAN) begin
        if (rd_en_o) issue_q <= issue_q + 1'b1;
        cmp_valid_q <= rd_en_o && !finish_w;
        cmp_slot_q  <= rd_slot_o;
        if (finish_w) begin
          state_q <= S_IDLE;
          done_q  <= 1'b1;
          hit_q   <= match_w;
          slot_q  <= cmp_slot_q;
          r_q     <= match_w ? rd_r_i : '0;
        end
      end
    end
  end

  assign busy_o = (state_q == S_SCAN);
  assign done_o = done_q;
  assign hit_o  = hit_q;
  assign slot_o = slot_q;
  assign r_o    = r_q;

  p_rd_in_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> busy_o);
  p_slot_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o && $past(rd_en_o) |-> rd_slot_o == $past(rd_slot_o) + 1'b1);
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_result_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(hit_o) && $stable(slot_o) && $stable(r_o));
endmodule

// File: rtl/hpt_group_search.sv
module hpt_group_search #(
  parameter int DW         = 64,
  parameter int SLOTS      = 8,
  parameter int NUM_PSIZE  = 4,
  parameter int AVPN_SHIFT = 11,
  localparam int PSW    = $clog2(NUM_PSIZE),
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DW-1:0]     vpn_i,
  input  logic [PSW-1:0]    base_psize_i,
  input  logic [PSW-1:0]    act_psize_i,
  input  logic [1:0]        ssize_i,
  input  logic              secondary_i,
  input  logic              cfg_we_i,
  input  logic [PSW-1:0]    cfg_idx_i,
  input  logic [DW-1:0]     cfg_mask_i,
  output logic              rd_en_o,
  output logic [SLOT_W-1:0] rd_slot_o,
  input  logic [DW-1:0]     rd_v_i,
  input  logic [DW-1:0]     rd_r_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              hit_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [DW-1:0]     r_o,
  output logic [DW-1:0]     exp_v_o
);
  logic [DW-1:0] mask_w;
  logic [DW-1:0] key_w;
  logic          sec_w;
  logic          load_w;

  hpt_mask_table #(.DW(DW), .NUM_PSIZE(NUM_PSIZE)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .widx_i  (cfg_idx_i),
    .wdata_i (cfg_mask_i),
    .ridx_i  (base_psize_i),
    .rdata_o (mask_w)
  );

  hpt_key_build #(.DW(DW), .PSW(PSW), .AVPN_SHIFT(AVPN_SHIFT)) u_key (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_w),
    .busy_i      (busy_o),
    .vpn_i       (vpn_i),
    .mask_i      (mask_w),
    .act_psize_i (act_psize_i),
    .ssize_i     (ssize_i),
    .sec_i       (secondary_i),
    .key_o       (key_w),
    .sec_o       (sec_w)
  );

  hpt_group_scan #(.DW(DW), .SLOTS(SLOTS)) u_scan (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .key_i     (key_w),
    .sec_i     (sec_w),
    .load_o    (load_w),
    .rd_en_o   (rd_en_o),
    .rd_slot_o (rd_slot_o),
    .rd_v_i    (rd_v_i),
    .rd_r_i    (rd_r_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .hit_o     (hit_o),
    .slot_o    (slot_o),
    .r_o       (r_o)
  );

  assign exp_v_o = key_w;

  p_slot_trace_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(rd_en_o, 2) &&
               ((hit_o ? slot_o : SLOT_W'(SLOTS-1)) == $past(rd_slot_o, 2)));
  p_start_loads_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);
endmodule

// File: tb/hpt_group_search_tb_top.sv
module hpt_group_search_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start = 1'b0;
  logic [63:0] vpn = '0;
  logic [1:0]  base_ps = '0, act_ps = '0, ssz = '0;
  logic        sec = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [63:0] cfg_mask = '0;
  logic        rd_en;
  logic [2:0]  rd_slot;
  logic [63:0] rd_v = '0, rd_r = '0;
  logic        busy, done, hit;
  logic [2:0]  slot;
  logic [63:0] r_out, exp_v;

  logic [63:0] mem_v [8];
  logic [63:0] mem_r [8];
  logic [63:0] mask_m [4];

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  typedef struct {
    logic        hit;
    int          slot;
    logic [63:0] r;
    int          lat;
    int          t0;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  hpt_group_search dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .vpn_i(vpn),
    .base_psize_i(base_ps), .act_psize_i(act_ps), .ssize_i(ssz),
    .secondary_i(sec), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
    .cfg_mask_i(cfg_mask), .rd_en_o(rd_en), .rd_slot_o(rd_slot),
    .rd_v_i(rd_v), .rd_r_i(rd_r), .busy_o(busy), .done_o(done),
    .hit_o(hit), .slot_o(slot), .r_o(r_out), .exp_v_o(exp_v)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd_en) begin
      rd_v <= mem_v[rd_slot];
      rd_r <= mem_r[rd_slot];
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  function automatic logic [63:0] key_of(input logic [63:0] v, input logic [1:0] b,
                                         input logic [1:0] a, input logic [1:0] s);
    logic [63:0] k;
    k = (((v >> 11) & ~mask_m[b]) << 7) | ({62'b0, s} << 62);
    k[2] = (a != 2'd0);
    return k;
  endfunction

  // Monitor: pop expected results as done strobes appear
  always @(negedge clk) begin
    if (rst_ni && done) begin
      if (q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R10: unexpected done, actual 1 expected 0");
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " hit"}, {63'b0, hit}, {63'b0, e.hit});
        chk({e.tag, " slot"}, {61'b0, slot}, 64'(e.slot));
        chk({e.tag, " r"}, r_out, e.r);
        chk({e.tag, " R8 latency"}, 64'(cyc - e.t0), 64'(e.lat));
      end
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < 8; i++) begin
      mem_v[i] = 64'h0;
      mem_r[i] = 64'h1000 + 64'(i);
    end
  endtask

  task automatic wr_mask(input logic [1:0] idx, input logic [63:0] m);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_mask = m;
    @(negedge clk);
    cfg_we = 1'b0;
    mask_m[idx] = m;
  endtask

  task automatic search(input logic [63:0] v, input logic [1:0] b, input logic [1:0] a,
                        input logic [1:0] s, input logic sc, input logic eh,
                        input int es, input string tag, input logic disturb);
    exp_t e;
    logic [63:0] k;
    k = key_of(v, b, a, s);
    @(negedge clk);
    vpn = v; base_ps = b; act_ps = a; ssz = s; sec = sc; start = 1'b1;
    e.hit = eh; e.slot = eh ? es : 7; e.r = eh ? mem_r[es] : 64'h0;
    e.lat = eh ? es + 3 : 10; e.t0 = cyc; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R2 R3 key"}, exp_v, k);
    if (disturb) begin
      vpn = ~v; start = 1'b1;
      cfg_we = 1'b1; cfg_idx = b; cfg_mask = 64'hFFFF;
      @(negedge clk);
      start = 1'b0; cfg_we = 1'b0;
      mask_m[b] = 64'hFFFF;
      chk("R10 R11 key held", exp_v, k);
    end
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] k;
    logic        h0;
    logic [2:0]  s0;
    logic [63:0] r0;
    for (int i = 0; i < 4; i++) mask_m[i] = '0;
    clear_mem();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {63'b0, busy}, 64'h0);
    chk("R1 done", {63'b0, done}, 64'h0);
    chk("R1 hit", {63'b0, hit}, 64'h0);
    chk("R1 rd_en", {63'b0, rd_en}, 64'h0);
    chk("R1 key", exp_v, 64'h0);

    // R4: hit at slot 3, low flag bits differ; R3 large with act=2
    k = key_of(64'h0123_4567_89AB_CDEF, 2'd0, 2'd2, 2'd1);
    mem_v[3] = (k & ~64'h7F) | 64'h7D;
    search(64'h0123_4567_89AB_CDEF, 2'd0, 2'd2, 2'd1, 1'b0, 1'b1, 3, "R4", 1'b0);

    // R12: result holds while idle
    h0 = hit; s0 = slot; r0 = r_out;
    repeat (5) @(negedge clk);
    chk("R12 hit hold", {63'b0, hit}, {63'b0, h0});
    chk("R12 slot hold", {61'b0, slot}, {61'b0, s0});
    chk("R12 r hold", r_out, r0);

    // R11 + R2: mask for base size 1 clears low avpn bits
    clear_mem();
    wr_mask(2'd1, 64'h1F);
    k = key_of(64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 2'd0, 2'd0);
    mem_v[0] = k | 64'h1;
    search(64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 2'd0, 2'd0, 1'b0, 1'b1, 0, "R11", 1'b0);

    // R5: invalid matching entry at slot 2, valid at 5
    clear_mem();
    k = key_of(64'hDEAD_BEEF_0000_8000, 2'd0, 2'd0, 2'd0);
    mem_v[2] = k & ~64'h7F;
    mem_v[5] = (k & ~64'h7F) | 64'h1;
    search(64'hDEAD_BEEF_0000_8000, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 5, "R5", 1'b0);

    // R6: secondary mismatch at slot 0, match at 6
    clear_mem();
    k = key_of(64'h0000_1234_5678_0000, 2'd0, 2'd1, 2'd0);
    mem_v[0] = (k & ~64'h7F) | 64'h1;
    mem_v[6] = (k & ~64'h7F) | 64'h3;
    search(64'h0000_1234_5678_0000, 2'd0, 2'd1, 2'd0, 1'b1, 1'b1, 6, "R6", 1'b0);

    // R7: two hits, lowest wins
    clear_mem();
    k = key_of(64'h0000_0000_00AB_C800, 2'd0, 2'd0, 2'd2);
    mem_v[1] = (k & ~64'h7F) | 64'h11;
    mem_v[4] = (k & ~64'h7F) | 64'h1;
    search(64'h0000_0000_00AB_C800, 2'd0, 2'd0, 2'd2, 1'b0, 1'b1, 1, "R7", 1'b0);

    // R9 + R4: bit 7 and bit 63 differences miss
    clear_mem();
    k = key_of(64'h0000_0000_0F0F_0000, 2'd0, 2'd0, 2'd1);
    mem_v[0] = (k ^ 64'h80) | 64'h1;
    mem_v[7] = (k ^ 64'h8000_0000_0000_0000) | 64'h1;
    search(64'h0000_0000_0F0F_0000, 2'd0, 2'd0, 2'd1, 1'b0, 1'b0, 0, "R9", 1'b0);

    // R10 + R11: start and mask write during busy leave search alone
    clear_mem();
    k = key_of(64'h0000_00FF_FF00_0000, 2'd2, 2'd3, 2'd0);
    mem_v[6] = (k & ~64'h7F) | 64'h1;
    search(64'h0000_00FF_FF00_0000, 2'd2, 2'd3, 2'd0, 1'b0, 1'b1, 6, "R10", 1'b1);
    repeat (12) @(negedge clk);
    chk("R10 idle after", {63'b0, busy}, 64'h0);

    // R11: new mask in effect for the next search
    clear_mem();
    search(64'h0000_00FF_FF00_0000, 2'd2, 2'd3, 2'd0, 1'b0, 1'b0, 0, "R11 new", 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule